// File: doc/BRIEF.md
# Bounded Bit-Field Extract Unit

This is a purely combinational execute-stage unit for a 32-bit RISC-V style core. It recognises two custom instructions that pull a short run of adjacent bits out of a source operand. The result is returned zero-extended to the full register width. The field is between one and eight bits wide. Its width is coded in the instruction as width minus one, in a 3-bit field.

The two instruction forms share the custom-0 major opcode. In the register form, the start bit comes from the low five bits of the second operand. In the immediate form, the start bit is an immediate in the instruction word. Both forms read the width code from instruction bits [28:26]. Any encoding outside the two forms clears the match flag and forces the result to zero. The surrounding pipeline therefore needs no separate qualification before it steers the result.

Top module: `bfx_unit`

## Requirements
- R1: Register form: `inst[6:0]` = 0x0b, `inst[14:12]` = 0, `inst[31:29]` = 0 and `inst[25]` = 0 raise `hit`. The width code is `inst[28:26]` and the start bit is `rs2_val[4:0]`.
- R2: Immediate form: `inst[6:0]` = 0x0b, `inst[14:12]` = 4, `inst[31:29]` = 0 and `inst[25]` = 0 raise `hit`. The width code is `inst[28:26]` and the start bit is `inst[24:20]`.
- R3: On a match, `result` = (`rs1_val` >> start) & ((1 << (code+1)) - 1), for every start from 0 to 31 and every code from 0 to 7.
- R4: Result bits at or above the field width are zero. Positions past bit 31 of `rs1_val` read as zero.
- R5: `rs2_val[31:5]` has no effect in the register form. All of `rs2_val` has no effect in the immediate form.
- R6: Any other opcode or funct3, or a nonzero `inst[31:29]` or `inst[25]`, gives `hit` = 0 and `result` = 0.
- R7: Width code 7 selects the 8-bit mask 0xff. Width code 0 selects the 1-bit mask 0x01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst | input | 32 | Instruction word under decode |
| rs1_val | input | 32 | Source operand the field is taken from |
| rs2_val | input | 32 | Second operand; low five bits give the start bit in the register form |
| hit | output | 1 | High when the word is one of the two extract forms |
| result | output | 32 | Zero-extended extracted field, zero on a miss |

## Verification
The checker examines every input change. It confirms that a miss always yields a zero result and that the upper 24 result bits never carry data. It also confirms that a hit implies the custom opcode with clear reserved bits, that nothing sits above the coded width, and that result bit 0 matches the addressed `rs1_val` bit. Only the bench's scenarios can show the full field value. The bench sweeps all 256 width and start combinations in each form against an arithmetic model. Its scenarios also show that the unused `rs2_val` bits have no effect, that the zero fill past bit 31 is correct, and that each malformed encoding is rejected.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int XLEN  = 32;
  localparam int ILEN  = 32;
  localparam int SHW   = $clog2(XLEN);
  localparam int WCW   = 3;
  localparam int MAXW  = 1 << WCW;

  localparam logic [6:0] OPC_CUSTOM0 = 7'h0b;
  localparam logic [2:0] F3_REG_FORM = 3'd0;
  localparam logic [2:0] F3_IMM_FORM = 3'd4;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_REG  = 2'd1,
    FORM_IMM  = 2'd2
  } bfx_form_e;

  typedef struct packed {
    bfx_form_e        form;
    logic [SHW-1:0]   imm_shamt;
    logic [WCW-1:0]   wcode;
  } bfx_dec_t;

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [ILEN-1:0] inst,
  output bfx_dec_t        dec
);

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       rsvd_clear;
  logic       is_custom;

  assign opcode     = inst[6:0];
  assign funct3     = inst[14:12];
  assign rsvd_clear = (inst[31:29] == 3'b000) && !inst[25];
  assign is_custom  = (opcode == OPC_CUSTOM0) && rsvd_clear;

  always_comb begin
    dec.form = FORM_NONE;
    if (is_custom) begin
      if (funct3 == F3_REG_FORM) begin
        dec.form = FORM_REG;
      end else if (funct3 == F3_IMM_FORM) begin
        dec.form = FORM_IMM;
      end
    end
  end

  assign dec.imm_shamt = inst[20 +: SHW];
  assign dec.wcode     = inst[26 +: WCW];

  logic unused_fields;
  assign unused_fields = ^{inst[19:15], inst[11:7]};

endmodule

// File: rtl/bfx_shift.sv
module bfx_shift
  import bfx_pkg::*;
#(
  parameter int DW  = XLEN,
  parameter int SW  = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? (stage[k] >> STEP) : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask
  import bfx_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int CW = WCW
) (
  input  logic [CW-1:0] code,
  output logic [DW-1:0] mask
);

  localparam int SPAN = 1 << CW;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i < SPAN) begin : g_live
      assign mask[i] = (i <= int'(code));
    end else begin : g_dead
      assign mask[i] = 1'b0;
    end
  end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
(
  input  logic [ILEN-1:0] inst,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic            hit,
  output logic [XLEN-1:0] result
);

  bfx_dec_t       dec;
  logic [SHW-1:0] shamt;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] field_mask;

  bfx_decode u_decode (
    .inst (inst),
    .dec  (dec)
  );

  always_comb begin
    unique case (dec.form)
      FORM_REG: shamt = rs2_val[SHW-1:0];
      FORM_IMM: shamt = dec.imm_shamt;
      default:  shamt = '0;
    endcase
  end

  bfx_shift #(.DW(XLEN), .SW(SHW)) u_shift (
    .din  (rs1_val),
    .amt  (shamt),
    .dout (shifted)
  );

  bfx_mask #(.DW(XLEN), .CW(WCW)) u_mask (
    .code (dec.wcode),
    .mask (field_mask)
  );

  assign hit    = (dec.form != FORM_NONE);
  assign result = hit ? (shifted & field_mask) : '0;

  logic unused_rs2_hi;
  assign unused_rs2_hi = ^rs2_val[XLEN-1:SHW];

endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk
  import bfx_pkg::*;
(
  input logic [ILEN-1:0] inst,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic            hit,
  input logic [XLEN-1:0] result
);

  logic [SHW-1:0] sel_start;
  assign sel_start = (inst[14:12] == F3_REG_FORM) ? rs2_val[SHW-1:0] : inst[20 +: SHW];

  always_comb begin
    if (!$isunknown({inst, rs1_val, rs2_val, hit, result})) begin
      a_r6_miss_zero: assert (hit || result == '0)
        else $error("miss with nonzero result");
      a_r4_upper_zero: assert (result[XLEN-1:MAXW] == '0)
        else $error("data above widest field");
      a_r1_rsvd_clear: assert (!hit || (inst[6:0] == OPC_CUSTOM0 && inst[31:29] == 3'b000 && !inst[25]))
        else $error("hit on malformed word");
      a_r7_width_bound: assert (!hit || ((result >> (int'(inst[28:26]) + 1)) == '0))
        else $error("result wider than coded width");
      a_r3_low_bit: assert (!hit || result[0] == rs1_val[sel_start])
        else $error("bit 0 not the start bit");
    end
  end

endmodule

bind bfx_unit bfx_unit_chk u_chk (.*);

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] inst;
  logic [31:0] rs1_val;
  logic [31:0] rs2_val;
  logic        hit;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bfx_unit u_dut (
    .inst    (inst),
    .rs1_val (rs1_val),
    .rs2_val (rs2_val),
    .hit     (hit),
    .result  (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] enc_reg(input logic [2:0] code);
    return {3'b000, code, 1'b0, 5'd7, 5'd9, 3'd0, 5'd3, 7'h0b};
  endfunction

  function automatic logic [31:0] enc_imm(input logic [4:0] sh, input logic [2:0] code);
    return {3'b000, code, 1'b0, sh, 5'd9, 3'd4, 5'd3, 7'h0b};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input int sh, input int w);
    return (a >> sh) & ((32'h1 << w) - 32'h1);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inst = i; rs1_val = a; rs2_val = b;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2, keep;
    rst_n = 1'b0;
    inst = '0; rs1_val = '0; rs2_val = '0;
    repeat (3) @(posedge clk);
    // R6: idle all-zero word is not an extract
    check("R6 idle hit", {31'd0, hit}, 32'd0);
    check("R6 idle result", result, 32'd0);
    rst_n = 1'b1;

    // R1 R3 R5: register form sweep, random upper rs2 bits
    for (int w = 1; w <= 8; w++) begin
      for (int sh = 0; sh < 32; sh++) begin
        r1 = $urandom;
        r2 = {$urandom} & 32'hffff_ffe0 | 32'(sh);
        apply(enc_reg(3'(w - 1)), r1, r2);
        check("R1 reg hit", {31'd0, hit}, 32'd1);
        check("R3 reg field", result, model(r1, sh, w));
      end
    end

    // R2 R3 R5: immediate form sweep, rs2 fully random
    for (int w = 1; w <= 8; w++) begin
      for (int sh = 0; sh < 32; sh++) begin
        r1 = $urandom;
        r2 = $urandom;
        apply(enc_imm(5'(sh), 3'(w - 1)), r1, r2);
        check("R2 imm hit", {31'd0, hit}, 32'd1);
        check("R3 imm field", result, model(r1, sh, w));
      end
    end

    // R4: zero fill past bit 31
    apply(enc_imm(5'd28, 3'd7), 32'hffff_ffff, 32'h0);
    check("R4 fill sh28", result, 32'h0000_000f);
    apply(enc_reg(3'd7), 32'hffff_ffff, 32'd31);
    check("R4 fill sh31", result, 32'h0000_0001);
    apply(enc_imm(5'd4, 3'd2), 32'hffff_ffff, 32'h0);
    check("R4 above width", result, 32'h0000_0007);

    // R7: widest and narrowest masks
    apply(enc_imm(5'd0, 3'd7), 32'hffff_ffff, 32'h0);
    check("R7 code7 mask", result, 32'h0000_00ff);
    apply(enc_imm(5'd0, 3'd0), 32'hffff_ffff, 32'h0);
    check("R7 code0 mask", result, 32'h0000_0001);

    // R5: unused rs2 bits have no effect
    apply(enc_imm(5'd8, 3'd7), 32'h1234_5678, 32'h0000_0000);
    keep = result;
    apply(enc_imm(5'd8, 3'd7), 32'h1234_5678, 32'hffff_ffff);
    check("R5 imm rs2 ignored", result, keep);
    check("R5 imm value", keep, 32'h0000_0056);
    apply(enc_reg(3'd7), 32'h1234_5678, 32'h0000_0010);
    keep = result;
    apply(enc_reg(3'd7), 32'h1234_5678, 32'hffff_ffd0);
    check("R5 reg upper ignored", result, keep);
    check("R5 reg value", keep, 32'h0000_0034);

    // R6: malformed encodings
    apply(enc_imm(5'd0, 3'd7) | 32'h8000_0000, 32'hffff_ffff, 32'h0);
    check("R6 imm bit31 hit", {31'd0, hit}, 32'd0);
    check("R6 imm bit31 result", result, 32'd0);
    apply(enc_imm(5'd0, 3'd7) | 32'h2000_0000, 32'hffff_ffff, 32'h0);
    check("R6 imm bit29", {31'd0, hit}, 32'd0);
    apply(enc_imm(5'd0, 3'd7) | 32'h0200_0000, 32'hffff_ffff, 32'h0);
    check("R6 imm bit25", {31'd0, hit}, 32'd0);
    apply(enc_reg(3'd7) | 32'h0200_0000, 32'hffff_ffff, 32'h0);
    check("R6 reg bit25", {31'd0, hit}, 32'd0);
    apply(enc_reg(3'd7) | 32'h4000_0000, 32'hffff_ffff, 32'h0);
    check("R6 reg bit30 result", result, 32'd0);
    apply((enc_reg(3'd7) & ~32'h0000_7000) | 32'h0000_1000, 32'hffff_ffff, 32'h0);
    check("R6 funct3 1", {31'd0, hit}, 32'd0);
    apply((enc_imm(5'd0, 3'd7) & ~32'h0000_007f) | 32'h0000_002b, 32'hffff_ffff, 32'h0);
    check("R6 other opcode", {31'd0, hit}, 32'd0);
    check("R6 other opcode result", result, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule